// File: doc/BRIEF.md
# Control Register Target on a Two-Wire Serial Bus

This block is the bus-facing control port of a car-audio signal chain. It sits on a two-wire serial bus (I2C) as a target with a fixed 7-bit address. It holds thirteen 8-bit control registers that steer the signal chain. A write transaction carries a subaddress byte followed by data bytes. The subaddress byte holds a 4-bit register index and three flags that apply to that transaction only. The flags select whether the index advances after each byte, whether an offset-cancellation request is suppressed, and whether the test path is enabled.

A read transaction does not touch the registers. It returns a live status byte whose bit 3 reflects the stereo-pilot detector. The status byte is sampled again for every byte the controller acknowledges, so the controller can poll the detector repeatedly within one read.

SCL and SDA are oversampled by the system clock through synchronizer stages. The target drives SDA only by pulling it low.

Top module: `i2c_ctrl_regbank`

## Requirements
- R1: After reset, all thirteen registers read 8'hFE. SDA is released (not pulled low), and the auto-zero request and test-enable outputs are low.
- R2: The first byte after a start is the address byte. Address 7'b1000110 followed by R/W=0 (write) or R/W=1 (read) is acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge, and no later byte of that transaction is acknowledged or stored.
- R3: The first byte after the address in a write is the subaddress. Its bits 3..0 give the register index, bit 4 enables auto-increment, bit 5 is the test flag and bit 6 suppresses the auto-zero request. Bit 7 is ignored.
- R4: With auto-increment set, each data byte goes to the current index and then the index advances by one. Once the index reaches 12 it stays there, so later bytes overwrite register 12.
- R5: With auto-increment clear, every data byte of the transaction goes to the same index.
- R6: A data byte addressed to index 13, 14 or 15 is acknowledged, but no register changes.
- R7: Each data byte written to index 0 while subaddress bit 6 is clear raises the auto-zero request for exactly one clock. With bit 6 set, no request is raised.
- R8: The test-enable output equals the bit 5 flag of the most recent subaddress byte ANDed with bit 0 of register 10.
- R9: A read returns a byte with the stereo input in bit 3 and zeros elsewhere. The byte is sampled again at the end of every clock pulse that the controller acknowledges, and reading continues while the controller acknowledges. After a not-acknowledge, SDA is released.
- R10: A repeated start aborts the current transfer and begins a new address phase. A stop returns the target to idle with SDA released. Bit rates up to 500 kbit/s are supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low power-on reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| stereoIn | input | 1 | Stereo-pilot detector flag, returned in status bit 3 |
| sdaPullLow | output | 1 | High when the target pulls SDA low |
| regFlat | output | NUM_REGS*8 | Register contents, register k in bits [8k+7:8k] |
| autoZeroReq | output | 1 | One-clock request to start offset cancellation |
| testModeEn | output | 1 | Test path enable |

## Verification
The bench builds the block with its default parameters: thirteen registers, the fixed target address, a reset value of 8'hFE, register 10 as the test register, and two synchronizer stages. Because the subaddress carries a 4-bit index, indices 13 to 15 can be reached with these defaults, so writes that must be discarded and auto-increment stopping at index 12 can both be exercised. At the 50 MHz system clock the bench drives SCL at 500 kbit/s (100 clocks per bit). This shows the synchronizer latency is small enough to meet bus timing at the highest required rate.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;

  // Strobes from bus control to the register datapath.
  typedef struct packed {
    logic loadSub;    // rxByte holds a subaddress byte
    logic writeData;  // rxByte holds a data byte
  } bankStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } busState_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], lineIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= lineIn;
      end
    end
  endgenerate

  assign lineOut = pipe[STAGES-1];

endmodule

// File: rtl/i2c_bus_ctrl.sv
module i2c_bus_ctrl
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000110,
  parameter int         SYNC_STAGES = 2,
  parameter int         STATUS_POS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              stereoIn,
  output logic              sdaPullLow,
  output bankStrobe_t       strobe,
  output logic [BYTE_W-1:0] rxByte
);

  logic sclS, sdaS, sclPrev, sdaPrev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .lineIn(sclIn), .lineOut(sclS)
  );
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn), .lineOut(sdaS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  logic [BYTE_W-1:0] statusByte;
  always_comb begin
    statusByte             = '0;
    statusByte[STATUS_POS] = stereoIn;
  end

  busState_t         state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] txShift;
  logic              byteDone;
  logic              isRead;
  logic              masterAck;

  assign rxByte = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shReg      <= '0;
      txShift    <= '0;
      byteDone   <= 1'b0;
      isRead     <= 1'b0;
      masterAck  <= 1'b0;
      sdaPullLow <= 1'b0;
      strobe     <= '0;
    end else begin
      strobe <= '0;
      if (startDet) begin
        state      <= ST_ADDR;
        bitCnt     <= '0;
        byteDone   <= 1'b0;
        sdaPullLow <= 1'b0;
      end else if (stopDet) begin
        state      <= ST_IDLE;
        byteDone   <= 1'b0;
        sdaPullLow <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (sclRise) begin
              shReg  <= {shReg[BYTE_W-2:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
              if (bitCnt == 4'd7) byteDone <= 1'b1;
            end else if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              bitCnt   <= '0;
              case (state)
                ST_ADDR: begin
                  if (shReg[7:1] == DEV_ADDR) begin
                    isRead     <= shReg[0];
                    sdaPullLow <= 1'b1;
                    state      <= ST_ADDR_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_SUB: begin
                  strobe.loadSub <= 1'b1;
                  sdaPullLow     <= 1'b1;
                  state          <= ST_SUB_ACK;
                end
                default: begin
                  strobe.writeData <= 1'b1;
                  sdaPullLow       <= 1'b1;
                  state            <= ST_WDATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (isRead) begin
                txShift    <= statusByte;
                sdaPullLow <= ~statusByte[BYTE_W-1];
                state      <= ST_RDATA;
              end else begin
                sdaPullLow <= 1'b0;
                state      <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (sclFall) begin
              sdaPullLow <= 1'b0;
              state      <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
              if (bitCnt == 4'd7) byteDone <= 1'b1;
            end else if (sclFall) begin
              if (byteDone) begin
                byteDone   <= 1'b0;
                bitCnt     <= '0;
                sdaPullLow <= 1'b0;
                state      <= ST_RACK;
              end else begin
                txShift    <= {txShift[BYTE_W-2:0], 1'b0};
                sdaPullLow <= ~txShift[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              masterAck <= ~sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                txShift    <= statusByte;
                sdaPullLow <= ~statusByte[BYTE_W-1];
                state      <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: one byte is routed either to the subaddress or to data, never both.
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R2: SDA is pulled only in acknowledge slots or while sending read data.
  p_drive_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_ADDR || state == ST_SUB ||
     state == ST_WDATA || state == ST_RACK) |-> !sdaPullLow);

  // R10: a stop always leaves the target idle with SDA released.
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaPullLow));

  // R9: read data does not change while SCL is high.
  p_read_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDATA && sclS && sclPrev) |-> $stable(sdaPullLow));

endmodule

// File: rtl/i2c_reg_datapath.sv
module i2c_reg_datapath
  import i2c_regbank_pkg::*;
#(
  parameter int                NUM_REGS  = 13,
  parameter int                TEST_IDX  = 10,
  parameter logic [BYTE_W-1:0] RESET_VAL = 8'hFE
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrobe_t                strobe,
  input  logic [BYTE_W-1:0]          rxByte,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat,
  output logic                       autoZeroReq,
  output logic                       testModeEn
);

  localparam int LAST_IDX = NUM_REGS - 1;

  logic [IDX_W-1:0]  curIdx;
  logic              autoInc;
  logic              azRemain;
  logic              testFlag;
  logic [BYTE_W-1:0] bankRegs [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx      <= '0;
      autoInc     <= 1'b0;
      azRemain    <= 1'b0;
      testFlag    <= 1'b0;
      autoZeroReq <= 1'b0;
    end else begin
      autoZeroReq <= 1'b0;
      if (strobe.loadSub) begin
        curIdx   <= rxByte[IDX_W-1:0];
        autoInc  <= rxByte[4];
        testFlag <= rxByte[5];
        azRemain <= rxByte[6];
      end else if (strobe.writeData) begin
        if (autoInc && (curIdx < IDX_W'(LAST_IDX))) curIdx <= curIdx + 1'b1;
        if (curIdx == '0 && !azRemain) autoZeroReq <= 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          bankRegs[g] <= RESET_VAL;
        else if (strobe.writeData && curIdx == IDX_W'(g))
          bankRegs[g] <= rxByte;
      end
      assign regFlat[g*BYTE_W +: BYTE_W] = bankRegs[g];
    end
  endgenerate

  assign testModeEn = testFlag & bankRegs[TEST_IDX][0];

  // R7: a request only follows a data byte to index 0 with the suppress flag clear.
  p_az_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    autoZeroReq |-> ($past(strobe.writeData) && $past(curIdx) == '0 && !$past(azRemain)));

  // R4: auto-increment saturates at the last register.
  p_inc_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeData && autoInc && curIdx == IDX_W'(LAST_IDX)) |=> curIdx == IDX_W'(LAST_IDX));

  // R5: without auto-increment the index holds across data bytes.
  p_fixed_idx_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeData && !autoInc) |=> $stable(curIdx));

  // R6: bytes aimed past the bank leave every register untouched.
  p_discard_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeData && ({1'b0, curIdx} >= (IDX_W+1)'(NUM_REGS))) |=> $stable(regFlat));

endmodule

// File: rtl/i2c_ctrl_regbank.sv
module i2c_ctrl_regbank
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'b1000110,
  parameter int                NUM_REGS    = 13,
  parameter int                TEST_IDX    = 10,
  parameter logic [BYTE_W-1:0] RESET_VAL   = 8'hFE,
  parameter int                SYNC_STAGES = 2,
  parameter int                STATUS_POS  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic                       stereoIn,
  output logic                       sdaPullLow,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat,
  output logic                       autoZeroReq,
  output logic                       testModeEn
);

  bankStrobe_t       strobe;
  logic [BYTE_W-1:0] rxByte;

  i2c_bus_ctrl #(
    .DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES), .STATUS_POS(STATUS_POS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stereoIn(stereoIn),
    .sdaPullLow(sdaPullLow), .strobe(strobe), .rxByte(rxByte)
  );

  i2c_reg_datapath #(
    .NUM_REGS(NUM_REGS), .TEST_IDX(TEST_IDX), .RESET_VAL(RESET_VAL)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .regFlat(regFlat), .autoZeroReq(autoZeroReq), .testModeEn(testModeEn)
  );

endmodule

// File: tb/i2c_ctrl_regbank_bench.sv
module i2c_ctrl_regbank_bench;

  localparam int NREG = 13;
  localparam int Q    = 25;   // quarter bit: 100 clocks per bit = 500 kbit/s

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic stereoIn = 1'b0;
  logic sdaPullLow, autoZeroReq, testModeEn;
  logic [NREG*8-1:0] regFlat;
  wire sdaLine = mSda & ~sdaPullLow;

  i2c_ctrl_regbank u_i2c_ctrl_regbank (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .stereoIn(stereoIn),
    .sdaPullLow(sdaPullLow), .regFlat(regFlat),
    .autoZeroReq(autoZeroReq), .testModeEn(testModeEn)
  );

  int errors = 0;
  int checks = 0;
  int azCount = 0;
  int azExp = 0;
  logic [7:0] expRegs [NREG];
  logic expTFlag = 1'b0;

  always @(negedge clk) if (autoZeroReq) azCount++;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkBank(input string req);
    int bad = -1;
    checks++;
    for (int i = 0; i < NREG; i++)
      if (bad < 0 && regFlat[i*8 +: 8] !== expRegs[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s register %0d: actual=%0h expected=%0h",
               req, bad, regFlat[bad*8 +: 8], expRegs[bad]);
    end
  endtask

  function automatic logic expTest();
    return expTFlag & expRegs[10][0];
  endfunction

  task automatic busStart();
    mSda = 1'b1; waitCyc(Q);
    mScl = 1'b1; waitCyc(Q);
    mSda = 1'b0; waitCyc(Q);
    mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitCyc(Q);
    mScl = 1'b1; waitCyc(Q);
    mSda = 1'b1; waitCyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitCyc(Q);
      mScl = 1'b1; waitCyc(2*Q);
      mScl = 1'b0; waitCyc(Q);
    end
    mSda = 1'b1; waitCyc(Q);
    mScl = 1'b1; waitCyc(Q);
    acked = (sdaLine == 1'b0);
    waitCyc(Q);
    mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic readByte(input logic ackIt, input logic nextStereo, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitCyc(Q);
      mScl = 1'b1; waitCyc(Q);
      b[i] = sdaLine;
      waitCyc(Q);
      mScl = 1'b0; waitCyc(Q);
    end
    stereoIn = nextStereo;
    mSda = ~ackIt; waitCyc(Q);
    mScl = 1'b1; waitCyc(2*Q);
    mScl = 1'b0; waitCyc(Q);
    mSda = 1'b1;
  endtask

  // Reference model of one write transaction.
  task automatic modelWrite(input logic [7:0] sub, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] dv [3];
    int idx = int'(sub[3:0]);
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    expTFlag = sub[5];
    for (int k = 0; k < n; k++) begin
      if (idx < NREG) expRegs[idx] = dv[k];
      if (idx == 0 && !sub[6]) azExp++;
      if (sub[4] && idx < NREG - 1) idx++;
    end
  endtask

  task automatic writeTxn(input logic [7:0] sub, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                          output int nAck);
    logic a;
    logic [7:0] dv [3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    nAck = 0;
    busStart();
    sendByte(8'h8C, a); nAck += int'(a);
    sendByte(sub, a);   nAck += int'(a);
    for (int k = 0; k < n; k++) begin
      sendByte(dv[k], a); nAck += int'(a);
    end
    busStop();
    waitCyc(10);
    modelWrite(sub, n, d0, d1, d2);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nAck;
    logic a;
    logic [7:0] rb;
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < NREG; i++) expRegs[i] = 8'hFE;

    waitCyc(5);
    rstN = 1'b1;
    waitCyc(10);

    // R1: reset state
    checkBank("R1");
    check("R1", "sda released", sdaLine, 1);
    check("R1", "autoZeroReq", autoZeroReq, 0);
    check("R1", "testModeEn", testModeEn, 0);

    // R2: wrong address gets no acknowledge and stores nothing
    busStart();
    sendByte(8'h8E, a);
    check("R2", "mismatch address ack", a, 0);
    sendByte(8'h02, a);
    check("R2", "mismatch subaddress ack", a, 0);
    sendByte(8'h55, a);
    busStop();
    waitCyc(10);
    checkBank("R2");

    // R4: auto-increment from 11 saturates at 12
    writeTxn(8'h1B, 3, 8'hA1, 8'hA2, 8'hA3, nAck);
    check("R2", "write acks", nAck, 5);
    checkBank("R4");

    // R5: fixed index
    writeTxn(8'h03, 3, 8'h31, 8'h32, 8'h33, nAck);
    checkBank("R5");

    // R3: bit 7 ignored, auto-increment from 2
    writeTxn(8'h92, 3, 8'h21, 8'h22, 8'h23, nAck);
    checkBank("R3");

    // R6: index 14 acknowledged and discarded
    writeTxn(8'h0E, 2, 8'h77, 8'h66, 8'h00, nAck);
    check("R6", "out-of-range acks", nAck, 4);
    checkBank("R6");

    // R7: auto-zero suppressed, then requested twice
    writeTxn(8'h40, 1, 8'h10, 8'h00, 8'h00, nAck);
    check("R7", "suppressed request count", azCount, 0);
    writeTxn(8'h00, 2, 8'h11, 8'h12, 8'h00, nAck);
    check("R7", "request count", azCount, 2);
    checkBank("R7");

    // R8: test enable needs flag and register 10 bit 0
    writeTxn(8'h2A, 1, 8'h01, 8'h00, 8'h00, nAck);
    check("R8", "testModeEn on", testModeEn, 1);
    writeTxn(8'h0A, 1, 8'h03, 8'h00, 8'h00, nAck);
    check("R8", "testModeEn flag clear", testModeEn, 0);

    // R9: live status, refreshed per acknowledged byte
    stereoIn = 1'b1;
    busStart();
    sendByte(8'h8D, a);
    check("R2", "read address ack", a, 1);
    readByte(1'b1, 1'b0, rb);
    check("R9", "status byte 0", rb, 8'h08);
    readByte(1'b1, 1'b1, rb);
    check("R9", "status byte 1", rb, 8'h00);
    readByte(1'b0, 1'b0, rb);
    check("R9", "status byte 2", rb, 8'h08);
    waitCyc(5);
    check("R9", "sda released after nack", sdaLine, 1);
    busStop();
    waitCyc(10);
    checkBank("R9");

    // R10: repeated start opens a new address phase
    busStart();
    sendByte(8'h8C, a);
    sendByte(8'h05, a);
    sendByte(8'h5A, a);
    busStart();
    sendByte(8'h8C, a);
    check("R10", "ack after repeated start", a, 1);
    sendByte(8'h06, a);
    sendByte(8'hA5, a);
    busStop();
    waitCyc(10);
    modelWrite(8'h05, 1, 8'h5A, 8'h00, 8'h00);
    modelWrite(8'h06, 1, 8'hA5, 8'h00, 8'h00);
    checkBank("R10");
    check("R10", "sda released after stop", sdaLine, 1);

    // Random write transactions against the model
    for (int t = 0; t < 12; t++) begin
      logic [7:0] sub;
      int n;
      sub = 8'($urandom);
      if (t % 3 == 0) sub[3:0] = 4'd10;
      n = 1 + int'($urandom % 3);
      writeTxn(sub, n, 8'($urandom), 8'($urandom), 8'($urandom), nAck);
      check("R2", "random acks", nAck, n + 2);
      checkBank("R3 R4 R5 R6 random");
      check("R7", "random request count", azCount, azExp);
      check("R8", "random testModeEn", testModeEn, expTest());
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule